// File: doc/BRIEF.md
# Timer Event Capture Unit

This block sits beside a 16-bit free-running counter and records the counter value at the moment a trigger event occurs. The trigger comes either from an external pin or from an analog comparator output; a select input chooses which one. The selected signal is synchronized, and the configured edge (rising or falling) loads the current count into a 16-bit capture register. The same edge sets a capture flag. The capture register is also driven out continuously, so the counter can use it as its wrap (TOP) value.

Software reaches the block over an 8-bit register bus. The 16-bit capture register is read and written one byte at a time through a single shared high-byte holding register, which makes each 16-bit access atomic. Reading the low byte snapshots the high byte into the holding register. Writing goes high byte first, into the holding register, and the low-byte write then commits all 16 bits in one cycle. A mask register holds the capture interrupt enable. The interrupt request is raised when the flag, that enable and the global interrupt enable are all set.

Top module: `evt_capture`

## Requirements
- R1: On an active edge of the selected trigger, the capture register loads `cntVal`. A change applied to the trigger input is captured at the third rising clock edge after it: two synchronizer stages plus one edge-compare stage.
- R2: `srcSel`=0 selects `pinIn` and `srcSel`=1 selects `cmpIn`. Edges on the unselected input cause no capture.
- R3: `edgeSel`=1 makes rising edges active and `edgeSel`=0 makes falling edges active. The opposite edge causes no capture.
- R4: A read at address 0 returns capture bits 7:0 and, at that clock edge, copies capture bits 15:8 into the holding register. A read at address 1 returns the holding register.
- R5: A write at address 1 loads only the holding register. A write at address 0 loads the capture register with {holding, write data} in a single clock edge.
- R6: `irq` is 1 exactly when the capture flag, mask bit 5 and `gie` are all 1.
- R7: The mask register is at address 2. Bits 7, 6 and 4 read as 0 and ignore writes. Bits 5 and 3:0 are read/write.
- R8: `topVal` always equals the capture register.
- R9: The capture flag reads at address 3, bit 5. A capture sets it, and writing 1 to bit 5 of address 3 clears it. A capture in the same cycle as a clear leaves the flag set.
- R10: A new capture overwrites the capture register even if the previous value was never read. A capture in the same cycle as a low-byte write wins, and the captured count is kept.
- R11: After reset, the capture register, holding register, mask and flag are 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cntVal | input | 16 | Current counter value |
| pinIn | input | 1 | External capture pin (asynchronous) |
| cmpIn | input | 1 | Analog comparator output (asynchronous) |
| srcSel | input | 1 | Trigger source: 0 pin, 1 comparator |
| edgeSel | input | 1 | Active edge: 1 rising, 0 falling |
| gie | input | 1 | Global interrupt enable |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational from address) |
| topVal | output | 16 | Capture register, for use as counter TOP |
| irq | output | 1 | Capture interrupt request |

## Verification
Two pairs of events can land on the same clock edge. A trigger capture can coincide with a software flag clear, and a trigger capture can coincide with a software low-byte write to the capture register. The bench toggles the trigger, waits two clock edges, and drives the bus write so that it is active on exactly the third edge, when the capture happens. It then judges the outcome at the ports: the flag must still read as set, and `topVal` must hold the counter value rather than the written data.

// File: rtl/evt_capture_pkg.sv
package evt_capture_pkg;
  localparam int DATA_W   = 8;
  localparam int CNT_W    = 2 * DATA_W;
  localparam int ADDR_LO  = 0;
  localparam int ADDR_HI  = 1;
  localparam int ADDR_MSK = 2;
  localparam int ADDR_FLG = 3;
  localparam int IE_BIT   = 5;
  localparam int FLAG_BIT = 5;
  localparam logic [DATA_W-1:0] MASK_RW = 8'h2F;

  typedef struct packed {
    logic capEn;       // trigger edge: load count
    logic holdFromCap; // low-byte read: snapshot high byte
    logic holdFromBus; // high-byte write
    logic capFromBus;  // low-byte write: commit 16 bits
    logic maskWr;
    logic flagClr;
  } strobe_t;
endpackage

// File: rtl/evt_capture_ctrl.sv
module evt_capture_ctrl
  import evt_capture_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinIn,
  input  logic              cmpIn,
  input  logic              srcSel,
  input  logic              edgeSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              clrBit,
  output strobe_t           strobes
);
  logic                   rawTrig;
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   syncTrig;
  logic                   riseEvt;
  logic                   fallEvt;

  assign rawTrig = srcSel ? cmpIn : pinIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawTrig};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign syncTrig = syncQ[SYNC_STAGES-1];
  assign riseEvt  = syncTrig & ~prevQ;
  assign fallEvt  = ~syncTrig & prevQ;

  always_comb begin
    strobes             = '0;
    strobes.capEn       = edgeSel ? riseEvt : fallEvt;
    strobes.holdFromCap = busRdEn && (busAddr == ADDR_W'(ADDR_LO));
    strobes.holdFromBus = busWrEn && (busAddr == ADDR_W'(ADDR_HI));
    strobes.capFromBus  = busWrEn && (busAddr == ADDR_W'(ADDR_LO));
    strobes.maskWr      = busWrEn && (busAddr == ADDR_W'(ADDR_MSK));
    strobes.flagClr     = busWrEn && (busAddr == ADDR_W'(ADDR_FLG)) && clrBit;
  end
endmodule

// File: rtl/evt_capture_dp.sv
module evt_capture_dp
  import evt_capture_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [CNT_W-1:0]  capQ,
  output logic [DATA_W-1:0] holdQ,
  output logic [DATA_W-1:0] maskQ,
  output logic              flagQ,
  output logic [DATA_W-1:0] busRdata
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capQ  <= '0;
      holdQ <= '0;
      maskQ <= '0;
      flagQ <= 1'b0;
    end else begin
      if (strobes.capEn)           capQ <= cntVal;
      else if (strobes.capFromBus) capQ <= {holdQ, busWdata};

      if (strobes.holdFromCap)      holdQ <= capQ[CNT_W-1:DATA_W];
      else if (strobes.holdFromBus) holdQ <= busWdata;

      if (strobes.maskWr) maskQ <= busWdata & MASK_RW;

      if (strobes.capEn)        flagQ <= 1'b1;
      else if (strobes.flagClr) flagQ <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_W'(ADDR_LO):  busRdata = capQ[DATA_W-1:0];
      ADDR_W'(ADDR_HI):  busRdata = holdQ;
      ADDR_W'(ADDR_MSK): busRdata = maskQ;
      default:           busRdata[FLAG_BIT] = flagQ;
    endcase
  end
endmodule

// File: rtl/evt_capture.sv
module evt_capture
  import evt_capture_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              pinIn,
  input  logic              cmpIn,
  input  logic              srcSel,
  input  logic              edgeSel,
  input  logic              gie,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [CNT_W-1:0]  topVal,
  output logic              irq
);
  strobe_t           strobes;
  logic [CNT_W-1:0]  capQ;
  logic [DATA_W-1:0] holdQ;
  logic [DATA_W-1:0] maskQ;
  logic              flagQ;

  evt_capture_ctrl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .cmpIn(cmpIn), .srcSel(srcSel),
    .edgeSel(edgeSel), .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .clrBit(busWdata[FLAG_BIT]), .strobes(strobes)
  );

  evt_capture_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cntVal(cntVal),
    .busAddr(busAddr), .busWdata(busWdata), .capQ(capQ), .holdQ(holdQ),
    .maskQ(maskQ), .flagQ(flagQ), .busRdata(busRdata)
  );

  assign topVal = capQ;
  assign irq    = flagQ & maskQ[IE_BIT] & gie;
endmodule

// File: rtl/evt_capture_chk.sv
module evt_capture_chk
  import evt_capture_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              gie,
  input logic              irq,
  input logic [CNT_W-1:0]  cntVal,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdata,
  input logic [CNT_W-1:0]  topVal,
  input strobe_t           strobes,
  input logic [CNT_W-1:0]  capQ,
  input logic [DATA_W-1:0] holdQ,
  input logic              flagQ
);
  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capEn |=> capQ == $past(cntVal)); // R1
  AST_TOP_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.capEn && !strobes.capFromBus) |=> $stable(topVal)); // R8
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capEn |=> flagQ); // R9
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> gie); // R6
  AST_HOLD_COHERENT: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == ADDR_W'(ADDR_LO)) |=> holdQ == $past(capQ[CNT_W-1:DATA_W])); // R4
  AST_MASK_RSVD: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(ADDR_MSK)) |-> (busRdata[7:6] == 2'b00 && !busRdata[4])); // R7
endmodule

bind evt_capture evt_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .gie(gie), .irq(irq), .cntVal(cntVal),
  .busAddr(busAddr), .busRdEn(busRdEn), .busRdata(busRdata), .topVal(topVal),
  .strobes(strobes), .capQ(capQ), .holdQ(holdQ), .flagQ(flagQ)
);

// File: tb/tb_evt_capture.sv
module tb_evt_capture;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cntVal = '0;
  logic        pinIn = 1'b0, cmpIn = 1'b0, srcSel = 1'b0, edgeSel = 1'b1, gie = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [15:0] topVal;
  logic        irq;
  int          nChecks = 0, nFails = 0;
  bit          done = 1'b0;

  evt_capture dut (.*);

  always #10 clk = ~clk; // 50 MHz

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; busRdEn = 1'b1;
    #2 d = busRdata;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  // drive trigger and wait past the capture edge (third rising edge)
  task automatic drivePin(input logic v, input logic [15:0] cnt);
    cntVal = cnt; pinIn = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    busRead(2'd0, d); chk("R11 cap lo", d, 0);
    busRead(2'd1, d); chk("R11 cap hi", d, 0);
    busRead(2'd2, d); chk("R11 mask", d, 0);
    busRead(2'd3, d); chk("R11 flag", d, 0);
    chk("R11 irq", irq, 0);
  endtask

  task automatic testRiseCapture();
    logic [7:0] d;
    edgeSel = 1'b1;
    cntVal = 16'h1234; pinIn = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 no capture before third edge", topVal, 16'h0000);
    @(negedge clk);
    chk("R1 capture at third edge", topVal, 16'h1234);
    chk("R8 topVal", topVal, 16'h1234);
    busRead(2'd0, d); chk("R4 low byte", d, 8'h34);
    busRead(2'd1, d); chk("R4 high via holding", d, 8'h12);
    busRead(2'd3, d); chk("R9 flag set", d, 8'h20);
  endtask

  task automatic testIrq();
    logic [7:0] d;
    busWrite(2'd2, 8'h20);
    gie = 1'b1; #2 chk("R6 irq all set", irq, 1);
    gie = 1'b0; #2 chk("R6 irq gie off", irq, 0);
    gie = 1'b1;
    busWrite(2'd3, 8'h20);
    busRead(2'd3, d); chk("R9 flag cleared", d, 0);
    chk("R6 irq after clear", irq, 0);
  endtask

  task automatic testFallEdge();
    edgeSel = 1'b0;
    drivePin(1'b0, 16'h5566);
    chk("R3 falling captured", topVal, 16'h5566);
    drivePin(1'b1, 16'h7788);
    chk("R3 rising ignored", topVal, 16'h5566);
    drivePin(1'b0, 16'h9ABC);
    chk("R10 overwrite unread", topVal, 16'h9ABC);
    edgeSel = 1'b1;
  endtask

  task automatic testSource();
    srcSel = 1'b1;
    repeat (3) @(negedge clk);
    drivePin(1'b1, 16'h1111);
    chk("R2 pin ignored when comparator selected", topVal, 16'h9ABC);
    pinIn = 1'b0;
    cntVal = 16'h2222; cmpIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 comparator capture", topVal, 16'h2222);
    cmpIn = 1'b0;
    repeat (3) @(negedge clk);
    srcSel = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic testWrite16();
    logic [7:0] d;
    busWrite(2'd1, 8'hC3);
    chk("R5 high write alone keeps cap", topVal, 16'h2222);
    busRead(2'd1, d); chk("R5 holding loaded", d, 8'hC3);
    busWrite(2'd0, 8'h5A);
    chk("R5 low write commits", topVal, 16'hC35A);
    busWrite(2'd1, 8'h77);
    busRead(2'd0, d); chk("R5 low read", d, 8'h5A);
    busRead(2'd1, d); chk("R4 shared holding refreshed", d, 8'hC3);
  endtask

  task automatic testMask();
    logic [7:0] d;
    busWrite(2'd2, 8'hFF);
    busRead(2'd2, d); chk("R7 reserved bits zero", d, 8'h2F);
  endtask

  task automatic testClrCollide();
    logic [7:0] d;
    busWrite(2'd3, 8'h20);
    cntVal = 16'hBEEF; pinIn = 1'b1;
    repeat (2) @(negedge clk);
    busAddr = 2'd3; busWdata = 8'h20; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    busRead(2'd3, d); chk("R9 capture beats clear", d, 8'h20);
    chk("R6 irq with mask", irq, 1);
    drivePin(1'b0, 16'hBEEF);
  endtask

  task automatic testWrCollide();
    cntVal = 16'h4242; pinIn = 1'b1;
    repeat (2) @(negedge clk);
    busAddr = 2'd0; busWdata = 8'h99; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    chk("R10 capture beats low write", topVal, 16'h4242);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRiseCapture();
    testIrq();
    testFallEdge();
    testSource();
    testWrite16();
    testMask();
    testClrCollide();
    testWrCollide();
    repeat (2) @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule